// File: doc/BRIEF.md
# Packet Queue Slot Address Generator

This block turns a queue index into the byte address of a 64-byte packet slot inside a ring that lives in host memory. It also reports how full that ring is, using the producer (write) and consumer (read) indices. The ring is described by a base pointer and a size in bytes. The number of slots is the size divided by 64, and it must be a power of two so that wrapping an index reduces to a bit mask.

Two layouts are supported. In the flat layout every slot of the ring is reachable. In the mirrored layout, which some older queue formats use, the ring is allocated at twice the size actually used. The upper half aliases the lower half, so an index wraps at half the slot count. The translated address is registered and appears one clock after the index is presented. The occupancy outputs are combinational in the write and read indices.

Top module: `ring_slot_addr_gen`

## Requirements
- R1: While reset is asserted, and after it until the first clock edge with reset released, `slot_addr` is zero.
- R2: With `mirror_sel` = 0, `slot_addr` one clock after an edge equals base + (index mod E) × 64, where E = `ring_bytes` / 64 and all operands are sampled at that edge.
- R3: With `mirror_sel` = 1, `slot_addr` one clock later equals base + (index mod (E/2)) × 64.
- R4: `used` equals `wr_idx` − `rd_idx`, taken modulo 2^64.
- R5: `remaining` equals E − `used`.
- R6: `full` is 1 exactly when `remaining` is zero.
- R7: `empty` is 1 exactly when `remaining` equals E, which means the two indices are equal.
- R8: Wrapping: in flat mode an index equal to E maps to the base address. In mirrored mode an index equal to E/2 maps to the base address, and index E/2+1 maps to base + 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 64 | Byte address of slot 0 |
| ring_bytes | input | 32 | Ring size in bytes (64 × power of two) |
| mirror_sel | input | 1 | 1 selects the half-mirrored layout |
| wr_idx | input | 64 | Producer index |
| rd_idx | input | 64 | Consumer index |
| xlat_idx | input | 64 | Index to translate |
| slot_addr | output | 64 | Registered slot byte address |
| used | output | 64 | Occupied slot count |
| remaining | output | 64 | Free slot count |
| full | output | 1 | No free slot |
| empty | output | 1 | No occupied slot |

## Verification
A wrong wrap mask shows up as a slot address past the ring end, or as one aliased into the wrong half. This becomes visible on the first edge after any index that is at least the wrap span. The random indices reach it almost at once, and the directed wrap cases at E and E/2 pin down the boundary. A wrong layout selection shows only in mirrored mode for indices in the upper half. An occupancy fault appears in the same cycle as the index change, because those outputs are combinational.

// File: rtl/rsag_pkg.sv
package rsag_pkg;
   typedef enum logic {
      LAYOUT_FLAT   = 1'b0,
      LAYOUT_MIRROR = 1'b1
   } layout_e;
endpackage

// File: rtl/rsag_slot_mask.sv
module rsag_slot_mask
   import rsag_pkg::*;
#(
   parameter int IDX_W      = 64,
   parameter int SIZE_W     = 32,
   parameter int SLOT_SHIFT = 6,
   parameter bit MIRROR_EN  = 1'b1
) (
   input  logic [SIZE_W-1:0] ring_bytes,
   input  logic              mirror_sel,
   output logic [IDX_W-1:0]  elems,
   output logic [IDX_W-1:0]  wrap_mask
);
   localparam int EW = SIZE_W - SLOT_SHIFT;

   logic [EW-1:0]         slot_cnt;
   logic [EW-1:0]         span;
   logic [SLOT_SHIFT-1:0] unused_low;

   assign slot_cnt   = ring_bytes[SIZE_W-1:SLOT_SHIFT];
   assign unused_low = ring_bytes[SLOT_SHIFT-1:0];
   assign elems      = {{(IDX_W-EW){1'b0}}, slot_cnt};

   generate
      if (MIRROR_EN) begin : g_mirror
         layout_e lay;
         assign lay  = layout_e'(mirror_sel);
         assign span = (lay == LAYOUT_MIRROR) ? (slot_cnt >> 1) : slot_cnt;
      end else begin : g_flat
         logic unused_sel;
         assign unused_sel = mirror_sel;
         assign span       = slot_cnt;
      end
   endgenerate

   always_comb begin
      if (span == '0) wrap_mask = '0;
      else            wrap_mask = {{(IDX_W-EW){1'b0}}, span - EW'(1)};
   end
endmodule

// File: rtl/rsag_occupancy.sv
module rsag_occupancy #(
   parameter int IDX_W = 64
) (
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [IDX_W-1:0] elems,
   output logic [IDX_W-1:0] used,
   output logic [IDX_W-1:0] remaining,
   output logic             full,
   output logic             empty
);
   always_comb begin
      used      = wr_idx - rd_idx;
      remaining = elems - used;
      full      = (remaining == '0);
      empty     = (remaining == elems);
   end
endmodule

// File: rtl/rsag_addr_stage.sv
module rsag_addr_stage #(
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 64,
   parameter int SLOT_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [IDX_W-1:0]  xlat_idx,
   input  logic [IDX_W-1:0]  wrap_mask,
   output logic [ADDR_W-1:0] slot_addr
);
   logic [IDX_W-1:0]  slot_no;
   logic [ADDR_W-1:0] byte_off;

   assign slot_no  = xlat_idx & wrap_mask;
   assign byte_off = ADDR_W'(slot_no) << SLOT_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) slot_addr <= '0;
      else        slot_addr <= base_addr + byte_off;
   end
endmodule

// File: rtl/ring_slot_addr_gen.sv
module ring_slot_addr_gen #(
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 64,
   parameter int SIZE_W     = 32,
   parameter int SLOT_BYTES = 64,
   parameter bit MIRROR_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [SIZE_W-1:0] ring_bytes,
   input  logic              mirror_sel,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [IDX_W-1:0]  xlat_idx,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [IDX_W-1:0]  used,
   output logic [IDX_W-1:0]  remaining,
   output logic              full,
   output logic              empty
);
   localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

   generate
      if ((1 << SLOT_SHIFT) != SLOT_BYTES) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two");
      end
      if (SIZE_W <= SLOT_SHIFT || IDX_W <= SIZE_W - SLOT_SHIFT) begin : g_bad_w
         $error("SIZE_W/IDX_W inconsistent with SLOT_BYTES");
      end
   endgenerate

   logic [IDX_W-1:0] elems;
   logic [IDX_W-1:0] wrap_mask;

   rsag_slot_mask #(
      .IDX_W(IDX_W), .SIZE_W(SIZE_W), .SLOT_SHIFT(SLOT_SHIFT), .MIRROR_EN(MIRROR_EN)
   ) u_mask (
      .ring_bytes(ring_bytes), .mirror_sel(mirror_sel),
      .elems(elems), .wrap_mask(wrap_mask)
   );

   rsag_occupancy #(.IDX_W(IDX_W)) u_occ (
      .wr_idx(wr_idx), .rd_idx(rd_idx), .elems(elems),
      .used(used), .remaining(remaining), .full(full), .empty(empty)
   );

   rsag_addr_stage #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_SHIFT(SLOT_SHIFT)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .xlat_idx(xlat_idx),
      .wrap_mask(wrap_mask), .slot_addr(slot_addr)
   );
endmodule

// File: rtl/rsag_checker.sv
module rsag_checker #(
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 64,
   parameter int SIZE_W     = 32,
   parameter int SLOT_BYTES = 64,
   parameter bit MIRROR_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] base_addr,
   input logic [SIZE_W-1:0] ring_bytes,
   input logic              mirror_sel,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [IDX_W-1:0]  xlat_idx,
   input logic [ADDR_W-1:0] slot_addr,
   input logic [IDX_W-1:0]  used,
   input logic [IDX_W-1:0]  remaining,
   input logic              full,
   input logic              empty
);
   logic [IDX_W-1:0] n_slots;
   assign n_slots = IDX_W'(ring_bytes / SLOT_BYTES);

   a_r1_reset_zero: assert property (@(posedge clk)
      $past(!rst_n) |-> slot_addr == '0);

   a_r2_flat_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(mirror_sel) && $past(n_slots) != '0) |->
      slot_addr == $past(base_addr) +
                   ADDR_W'(($past(xlat_idx) % $past(n_slots)) * SLOT_BYTES));

   a_r3_mirror_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (MIRROR_EN && $past(rst_n) && $past(mirror_sel) && $past(n_slots) > 1) |->
      slot_addr == $past(base_addr) +
                   ADDR_W'(($past(xlat_idx) % ($past(n_slots) / 2)) * SLOT_BYTES));

   a_r4_used: assert property (@(posedge clk) disable iff (!rst_n)
      used + rd_idx == wr_idx);

   a_r5_remaining: assert property (@(posedge clk) disable iff (!rst_n)
      remaining + used == n_slots);

   a_r6_full: assert property (@(posedge clk) disable iff (!rst_n)
      full == (wr_idx - rd_idx == n_slots));

   a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (wr_idx == rd_idx));
endmodule

bind ring_slot_addr_gen rsag_checker #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W),
   .SLOT_BYTES(SLOT_BYTES), .MIRROR_EN(MIRROR_EN)
) u_rsag_chk (.*);

// File: tb/ring_slot_addr_gen_bench.sv
module ring_slot_addr_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] base_addr = '0;
   logic [31:0] ring_bytes = 32'd1024;
   logic        mirror_sel = 1'b0;
   logic [63:0] wr_idx = '0, rd_idx = '0, xlat_idx = '0;
   logic [63:0] slot_addr, used, remaining;
   logic        full, empty;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_slot_addr_gen u_ring_slot_addr_gen (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .ring_bytes(ring_bytes),
      .mirror_sel(mirror_sel), .wr_idx(wr_idx), .rd_idx(rd_idx), .xlat_idx(xlat_idx),
      .slot_addr(slot_addr), .used(used), .remaining(remaining),
      .full(full), .empty(empty)
   );

   function automatic logic [63:0] exp_addr(logic [63:0] b, logic [31:0] rb,
                                             logic m, logic [63:0] ix);
      logic [63:0] e;
      e = {32'd0, rb} / 64;
      if (m) e = e / 2;
      return b + (ix % e) * 64;
   endfunction

   task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_occ();
      logic [63:0] e, u, r;
      e = {32'd0, ring_bytes} / 64;
      u = wr_idx - rd_idx;
      r = e - u;
      chk64("R4 used", used, u);
      chk64("R5 remaining", remaining, r);
      chk64("R6 full", {63'd0, full}, {63'd0, r == 0});
      chk64("R7 empty", {63'd0, empty}, {63'd0, r == e});
   endtask

   // drive at a falling edge; address is registered at the next rising edge
   task automatic step(string req, logic [63:0] b, logic [31:0] rb, logic m,
                       logic [63:0] ix, logic [63:0] w, logic [63:0] rd);
      base_addr = b; ring_bytes = rb; mirror_sel = m;
      xlat_idx = ix; wr_idx = w; rd_idx = rd;
      @(negedge clk);
      chk64(req, slot_addr, exp_addr(b, rb, m, ix));
      chk_occ();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      base_addr = 64'hDEAD_0000;
      xlat_idx  = 64'd5;
      repeat (3) @(negedge clk);
      chk64("R1 reset", slot_addr, 64'd0);
      rst_n = 1'b1;
      chk64("R1 before first edge", slot_addr, 64'd0);
      @(negedge clk);

      // directed: R2 flat, R3 mirror, R8 wraps, R6/R7 boundaries
      step("R2 flat idx3", 64'h1000_0000, 32'd1024, 1'b0, 64'd3, 64'd0, 64'd0);
      chk64("R7 empty at equal idx", {63'd0, empty}, 64'd1);
      step("R8 flat wrap at E", 64'h1000_0000, 32'd1024, 1'b0, 64'd16, 64'd16, 64'd0);
      chk64("R8 flat addr", slot_addr, 64'h1000_0000);
      chk64("R6 full", {63'd0, full}, 64'd1);
      step("R3 mirror idx3", 64'h2000_0000, 32'd1024, 1'b1, 64'd3, 64'd20, 64'd5);
      step("R8 mirror wrap E/2", 64'h2000_0000, 32'd1024, 1'b1, 64'd8, 64'd7, 64'd0);
      chk64("R8 mirror addr", slot_addr, 64'h2000_0000);
      step("R8 mirror E/2+1", 64'h2000_0000, 32'd1024, 1'b1, 64'd9, 64'd7, 64'd0);
      chk64("R8 mirror addr+64", slot_addr, 64'h2000_0040);
      step("R4 index wrap 2^64", 64'h0, 32'd4096, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF,
           64'd2, 64'hFFFF_FFFF_FFFF_FFFE);
      chk64("R4 used across wrap", used, 64'd4);

      for (int i = 0; i < 300; i++) begin
         logic [63:0] b, rd, ix;
         logic [31:0] rb;
         logic [63:0] e, u;
         rb = 32'd64 << (1 + ($urandom % 12));
         e  = {32'd0, rb} / 64;
         b  = {$urandom, $urandom} & ~64'h3F;
         rd = {$urandom, $urandom};
         u  = ($urandom % 4 == 0) ? (($urandom % 2) ? e : 64'd0) : ({32'd0, $urandom} % (e + 1));
         ix = ($urandom % 2) ? {$urandom, $urandom} : {32'd0, $urandom % 32'(3 * e)};
         step(($urandom % 2) ? "R2 random" : "R2 random", b, rb, 1'b0, ix, rd + u, rd);
         step("R3 random", b, rb, 1'b1, ix, rd + u, rd);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule